// File: doc/BRIEF.md
# Free-Running Timer with Capture and Compare Flags

A 16-bit up-counter advances by one on every clock and can be loaded from a small synchronous register bus. Two compare registers are matched against the count on every cycle. Four capture inputs are synchronized, and their rising edges are detected. The first two inputs latch the count into read-only capture registers. All of these events land in an 8-bit status register as sticky flags. Bit 0 of the status register is a control bit: when it is 1, a match on compare register A returns the counter to zero.

Software clears a flag with a two-step handshake. It first reads the status register while the flag is 1, which arms that bit. It then writes 0 to that bit. A write of 1 to a flag has no effect. A write of 0 to a flag that was not armed also has no effect. Each arm is used up by the clearing write, and a hardware set that arrives in the same cycle as the clear takes precedence.

Register addresses on `addr_i`: 0 counter (read/write), 1 compare A, 2 compare B, 3 capture A (read-only), 4 capture B (read-only), 5 status (low 8 bits; upper bits read 0). Reads are combinational. A write takes effect at the clock edge that ends the strobe cycle.

Top module: `cc_timer`

## Requirements
- R1: After reset the status register reads 0x00, both compare registers read 0xFFFF and both capture registers read 0x0000.
- R2: A bus write to address 0 loads the counter, so the written value reads back in the next cycle. With no further write, the counter then rises by exactly 1 per clock.
- R3: Status bit 1 sets when the counter advances by increment from 0xFFFF to 0x0000.
- R4: Status bit 3 sets when the count equals compare A, and bit 2 sets when it equals compare B. With status bit 0 at 0, the counter keeps incrementing through a match.
- R5: With status bit 0 at 1, the counter is 0x0000 in the cycle after it equals compare A, and it continues counting from there.
- R6: A rising edge on cap_i[0] or cap_i[1] passes a 2-stage synchronizer and stores the counter value into capture A or B. The stored value equals the count visible in the cycle the input first went high, plus 2. The same event sets status bit 7 (A) or bit 6 (B).
- R7: A rising edge on cap_i[2] sets status bit 5, and a rising edge on cap_i[3] sets status bit 4. An input held high does not capture again.
- R8: Writing 1 to any of status bits 7..1 leaves that bit unchanged.
- R9: Writing 0 to a status flag clears it only if the status register was read while that flag was 1 since the last clearing write to that bit. Otherwise the flag stays set. The arm is used up by the clearing write.
- R10: If a flag's set condition occurs in the same cycle as a valid clearing write, the flag stays 1.
- R11: Status bit 0 is plain read/write storage, written from wdata_i[0] on every status write.
- R12: Bus writes to the capture addresses do not change the capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe; a status read arms set flags |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| cap_i | input | 4 | Asynchronous capture inputs, channels A..D |

## Verification
The bench targets the clear handshake from every side:
- A write of 1 that is ignored.
- A write of 0 without a prior read, which a design lacking the arm bit would wrongly honour.
- A write of 0 timed so that it lands in the same cycle as a counter wrap, where a design giving clear priority would lose the event.
- A second unarmed write after that cycle, which catches a design that never consumes the arm.

Captured values are checked against the exact synchronizer latency, so a stage that is missing or added shows up as an off-by-one count. The bench also checks the counter one cycle after a compare-A match with clearing enabled and with it disabled, and checks that the clearing match does not raise the wrap flag.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  typedef enum logic [2:0] {
    A_COUNT  = 3'd0,
    A_CMP_A  = 3'd1,
    A_CMP_B  = 3'd2,
    A_CAP_A  = 3'd3,
    A_CAP_B  = 3'd4,
    A_STATUS = 3'd5
  } reg_addr_e;

  localparam int N_CAP     = 4;
  localparam int N_CAP_REG = 2;
  localparam int ST_W      = 8;
  localparam int N_FLAG    = ST_W - 1;

  // status bit positions
  localparam int ST_CAP_A = 7;
  localparam int ST_CAP_B = 6;
  localparam int ST_CAP_C = 5;
  localparam int ST_CAP_D = 4;
  localparam int ST_CMP_A = 3;
  localparam int ST_CMP_B = 2;
  localparam int ST_WRAP  = 1;
  localparam int ST_CLR_A = 0;
endpackage

// File: rtl/cc_timer_counter.sv
module cc_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic             clr_on_a_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_a_o,
  output logic             match_b_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clr_hit;

  assign match_a_o = (cnt_q == cmp_a_i);
  assign match_b_o = (cnt_q == cmp_b_i);
  assign clr_hit   = clr_on_a_i && match_a_o;
  // wrap only counts when the increment itself rolls over
  assign wrap_o    = !load_i && !clr_hit && (cnt_q == CNT_MAX);

  always_comb begin
    if (load_i)       cnt_d = load_val_i;
    else if (clr_hit) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cc_timer_edge.sv
module cc_timer_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] && !last_q;
endmodule

// File: rtl/cc_timer_flags.sv
module cc_timer_flags #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wval_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, arm_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr_req;
    assign clr_req = wr_i && !wval_i[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else begin
        // set beats an armed clear
        flag_q[i] <= set_i[i] || (flag_q[i] && !(clr_req && arm_q[i]));
        if (clr_req)   arm_q[i] <= 1'b0;
        else if (rd_i) arm_q[i] <= arm_q[i] || flag_q[i];
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [N_CAP-1:0] cap_i
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cmp_a_q, cmp_b_q;
  logic [CNT_W-1:0]  cap_q [N_CAP_REG];
  logic [N_CAP-1:0]  cap_evt;
  logic              match_a, match_b, wrap;
  logic              clr_on_a_q;
  logic [N_FLAG-1:0] flag_q, flag_set;
  logic [ST_W-1:0]   status;
  logic              cnt_load, st_wr, st_rd;

  assign cnt_load = wr_i && (addr_i == A_COUNT);
  assign st_wr    = wr_i && (addr_i == A_STATUS);
  assign st_rd    = rd_i && (addr_i == A_STATUS);

  cc_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (wdata_i),
    .cmp_a_i    (cmp_a_q),
    .cmp_b_i    (cmp_b_q),
    .clr_on_a_i (clr_on_a_q),
    .cnt_o      (cnt_q),
    .match_a_o  (match_a),
    .match_b_o  (match_b),
    .wrap_o     (wrap)
  );

  for (genvar c = 0; c < N_CAP; c++) begin : g_edge
    cc_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (cap_i[c]),
      .rise_o (cap_evt[c])
    );
  end

  for (genvar c = 0; c < N_CAP_REG; c++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cap_q[c] <= '0;
      else if (cap_evt[c]) cap_q[c] <= cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_a_q    <= '1;
      cmp_b_q    <= '1;
      clr_on_a_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == A_CMP_A)  cmp_a_q    <= wdata_i;
      if (addr_i == A_CMP_B)  cmp_b_q    <= wdata_i;
      if (addr_i == A_STATUS) clr_on_a_q <= wdata_i[ST_CLR_A];
    end
  end

  // flag vector index i maps to status bit i+1
  always_comb begin
    flag_set                = '0;
    flag_set[ST_CAP_A - 1]  = cap_evt[0];
    flag_set[ST_CAP_B - 1]  = cap_evt[1];
    flag_set[ST_CAP_C - 1]  = cap_evt[2];
    flag_set[ST_CAP_D - 1]  = cap_evt[3];
    flag_set[ST_CMP_A - 1]  = match_a;
    flag_set[ST_CMP_B - 1]  = match_b;
    flag_set[ST_WRAP - 1]   = wrap;
  end

  cc_timer_flags #(.N(N_FLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .rd_i   (st_rd),
    .wr_i   (st_wr),
    .wval_i (wdata_i[ST_W-1:1]),
    .flag_o (flag_q)
  );

  assign status = {flag_q, clr_on_a_q};

  always_comb begin
    case (addr_i)
      A_COUNT:  rdata_o = cnt_q;
      A_CMP_A:  rdata_o = cmp_a_q;
      A_CMP_B:  rdata_o = cmp_b_q;
      A_CAP_A:  rdata_o = cap_q[0];
      A_CAP_B:  rdata_o = cap_q[1];
      A_STATUS: rdata_o = {{(CNT_W-ST_W){1'b0}}, status};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cnt_load,
  input logic             clr_on_a_q,
  input logic [CNT_W-1:0] cmp_a_q,
  input logic [7:0]       status,
  input logic             st_wr,
  input logic [7:0]       wlo,
  input logic             wr_i,
  input logic [2:0]       addr_i,
  input logic             cap_evt_a,
  input logic [CNT_W-1:0] cap_a
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  assert_wrap_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_load && !(clr_on_a_q && cnt_q == cmp_a_q) && cnt_q == MAXV) |=> status[1]);

  assert_run_through_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_on_a_q && !cnt_load && cnt_q == cmp_a_q)
      |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && status[3]);

  assert_match_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_on_a_q && !cnt_load && cnt_q == cmp_a_q) |=> (cnt_q == '0));

  assert_ctrl_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr |=> (status[0] == $past(wlo[0])));

  assert_cap_ro_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd3 && !cap_evt_a) |=> $stable(cap_a));

  for (genvar i = 1; i < 8; i++) begin : g_flag
    assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status[i] && !(st_wr && !wlo[i])) |=> status[i]);
    assert_write_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status[i] && st_wr && wlo[i]) |=> status[i]);
  end
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_q      (cnt_q),
  .cnt_load   (cnt_load),
  .clr_on_a_q (clr_on_a_q),
  .cmp_a_q    (cmp_a_q),
  .status     (status),
  .st_wr      (st_wr),
  .wlo        (wdata_i[7:0]),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .cap_evt_a  (cap_evt[0]),
  .cap_a      (cap_q[0])
);

// File: tb/sim_cc_timer.sv
`timescale 1ns/1ps
module sim_cc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  cap = '0;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [15:0] exp;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  cc_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap)
  );

  localparam logic [2:0] CNT = 3'd0, CMPA = 3'd1, CMPB = 3'd2,
                         CAPA = 3'd3, CAPB = 3'd4, STAT = 3'd5;

  // monitor: sample late in each low phase
  always begin
    @(negedge clk);
    #2;
    if (rd && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_err++;
        $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic rd_exp(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    wr = 0; rd = 1; addr = a;
    it.tag = tag; it.exp = e;
    exp_q.push_back(it);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    rd = 0; wr = 1; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd = 0; wr = 0;
    end
  endtask

  task automatic set_cap(input int ch, input logic v);
    @(negedge clk);
    rd = 0; wr = 0; cap[ch] = v;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_exp(STAT, 16'h0000, "R1 status");
    rd_exp(CMPA, 16'hFFFF, "R1 cmp A");
    rd_exp(CMPB, 16'hFFFF, "R1 cmp B");
    rd_exp(CAPA, 16'h0000, "R1 cap A");
    rd_exp(CAPB, 16'h0000, "R1 cap B");

    wr_reg(CMPA, 16'h4000);
    wr_reg(CMPB, 16'h5000);
    rd_exp(CMPA, 16'h4000, "R4 cmp A write");
    rd_exp(CMPB, 16'h5000, "R4 cmp B write");

    // R2 load and count
    wr_reg(CNT, 16'h1000);
    rd_exp(CNT, 16'h1000, "R2 load");
    idle(3);
    rd_exp(CNT, 16'h1004, "R2 increment");

    // R4 compare A, free run
    wr_reg(CNT, 16'h3FFE);
    idle(4);
    rd_exp(STAT, 16'h0008, "R4 match A flag");
    rd_exp(CNT, 16'h4003, "R4 runs through match");

    // R8 write one ignored, then armed clear (R9)
    wr_reg(STAT, 16'h0008);
    rd_exp(STAT, 16'h0008, "R8 write one ignored");
    wr_reg(STAT, 16'h0000);
    rd_exp(STAT, 16'h0000, "R9 armed clear");

    // R4 compare B, R9 unarmed clear ignored
    wr_reg(CNT, 16'h4FFF);
    idle(2);
    wr_reg(STAT, 16'h0000);
    rd_exp(STAT, 16'h0004, "R9 unarmed clear ignored / R4 match B");
    wr_reg(STAT, 16'h0000);
    rd_exp(STAT, 16'h0000, "R9 clear B");

    // R3 wrap
    wr_reg(CNT, 16'hFFFE);
    idle(2);
    rd_exp(STAT, 16'h0002, "R3 wrap flag");
    // R10 set beats clear in same cycle
    wr_reg(CNT, 16'hFFFE);
    idle(1);
    wr_reg(STAT, 16'h0000);
    wr_reg(STAT, 16'h0000);   // arm already used
    rd_exp(STAT, 16'h0002, "R10 set wins / R9 arm consumed");
    wr_reg(STAT, 16'h0000);
    rd_exp(STAT, 16'h0000, "R9 clear wrap");

    // R11 control bit, R5 clear on match
    wr_reg(STAT, 16'h0001);
    rd_exp(STAT, 16'h0001, "R11 control set");
    wr_reg(CNT, 16'h3FFD);
    idle(5);
    rd_exp(CNT, 16'h0001, "R5 clear on match A");
    rd_exp(STAT, 16'h0009, "R5 match flag, no wrap");
    wr_reg(STAT, 16'h0001);
    rd_exp(STAT, 16'h0001, "R11 control kept while clearing");
    wr_reg(STAT, 16'h0000);
    rd_exp(STAT, 16'h0000, "R11 control cleared");

    // R6 capture A
    wr_reg(CNT, 16'h2000);
    set_cap(0, 1'b1);
    idle(3);
    rd_exp(CAPA, 16'h2002, "R6 capture A value");
    rd_exp(STAT, 16'h0080, "R6 capture A flag");
    wr_reg(CAPA, 16'hBEEF);
    rd_exp(CAPA, 16'h2002, "R12 capture write ignored / R7 held high");
    set_cap(0, 1'b0);

    // R6 capture B
    wr_reg(CNT, 16'h2100);
    set_cap(1, 1'b1);
    idle(3);
    rd_exp(CAPB, 16'h2102, "R6 capture B value");
    rd_exp(STAT, 16'h00C0, "R6 capture B flag");
    set_cap(1, 1'b0);

    // R7 channels C and D
    @(negedge clk);
    rd = 0; wr = 0; cap[2] = 1'b1; cap[3] = 1'b1;
    idle(3);
    rd_exp(STAT, 16'h00F0, "R7 capture C/D flags");
    wr_reg(STAT, 16'h0000);
    rd_exp(STAT, 16'h0000, "R9 clear all capture flags");
    rd_exp(CAPA, 16'h2002, "R7 no recapture while high");
    idle(2);

    done = 1;
    summary();
    $finish;
  end
endmodule